// File: doc/BRIEF.md
# Bus Error Status Register Bank

This block holds four 32-bit status registers that record why a memory access failed and at which virtual byte address. A translation unit reports each failure with a single-cycle fault strobe. With the strobe come a direction flag (read or write), a flag for a missing or invalid translation entry, a flag for a memory type the system does not define, and the faulting byte address. The bank folds these into a cause word in slot 0 and stores the address in slot 1. Slots 2 and 3 are auxiliary words that only software writes.

Software reaches the bank through a one-cycle register port with a 4-bit slot index. Each slot shapes written data by its own rule: some bits are dropped, some are forced and some are mirrored. Every read is destructive. The read data appears combinationally in the cycle of the access, and the slot reads zero from the next clock edge. A fault-handling routine can therefore read the cause and the address once and leave the bank ready for the next failure.

Top module: `fault_status_bank`

## Requirements
- R1: After reset, every slot 0 to 3 reads as 0x00000000.
- R2: A read of slot 0 to 3 (sw_sel=1, sw_we=0) drives that slot's value on sw_rdata in the same cycle and clears the slot to zero at the following clock edge. When the port is idle or writing, sw_rdata is zero.
- R3: A software write to slot 0 stores data bits 7:0, forces bit 15 to one and clears every other bit.
- R4: A software write to slot 1 stores all 32 data bits unchanged.
- R5: A software write to slot 2 stores only the data bits selected by mask 0x000000B0. All other bits become zero.
- R6: A software write to slot 3 stores data bits 29:0 and copies data bit 29 into both bit 30 and bit 31.
- R7: A fault with the invalid-entry flag on a read (flt_is_write=0) sets bit 7 of slot 0, clears bit 15 and leaves all other bits of slot 0 as they were.
- R8: A fault with the invalid-entry flag on a write (flt_is_write=1) sets bits 15 and 7 of slot 0 (OR with 0x8080) and leaves all other bits as they were.
- R9: A fault with the undefined-type flag and without the invalid-entry flag loads slot 0 with 0x00000020 for a read or 0x00008020 for a write. When both flags are set, the invalid-entry rule (R7/R8) applies.
- R10: Every fault strobe loads slot 1 with the faulting byte address, zero-extended to 32 bits. A strobe with neither cause flag leaves slot 0 unchanged.
- R11: In a cycle with a fault strobe, the software write and the read-clear are suppressed for all slots. sw_rdata still shows the value the slot held before the fault.
- R12: For slot indices 4 to 15, a read returns zero and changes no slot, and a write changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_sel | input | 1 | Software access in this cycle |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_idx | input | IDX_W (4) | Slot index |
| sw_wdata | input | DATA_W (32) | Write data |
| sw_rdata | output | DATA_W (32) | Read data, valid in the cycle of a read |
| flt_strobe | input | 1 | Fault report, one cycle |
| flt_is_write | input | 1 | Faulting access was a write |
| flt_invalid | input | 1 | Translation entry was invalid |
| flt_undef | input | 1 | Memory type is undefined |
| flt_vaddr | input | ADDR_W (32) | Faulting virtual byte address |

## Verification
The bench uses the default parameters: 4-bit index, 32-bit data and a full 32-bit address. With these values, indices 4 and 5 sit beside the four real slots, so the out-of-range read and write behaviour is tested against its neighbours. Every bit of slot 1 can also take a fault address, which exposes any truncation during capture. Directed cycles place a fault and a software access in the same cycle and combine both cause flags. A long stretch of random traffic then mixes reads, writes, out-of-range indices and faults against the bench's own model.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
   // Number of implemented slots and their roles
   localparam int unsigned FSB_SLOTS = 4;
   localparam int unsigned FSB_W     = 32;

   typedef enum logic [1:0] {
      SLOT_CAUSE = 2'd0,
      SLOT_VADDR = 2'd1,
      SLOT_AUX   = 2'd2,
      SLOT_EXT   = 2'd3
   } fsb_slot_e;

   // Software shaping constants
   localparam logic [FSB_W-1:0] CAUSE_SW_KEEP  = 32'h0000_00FF;
   localparam logic [FSB_W-1:0] CAUSE_SW_FORCE = 32'h0000_8000;
   localparam logic [FSB_W-1:0] AUX_SW_KEEP    = 32'h0000_00B0;
   localparam int unsigned      EXT_SRC_BIT    = 29;

   // Cause encoding used by hardware capture
   localparam int unsigned      DIR_BIT        = 15;
   localparam int unsigned      INV_BIT        = 7;
   localparam logic [FSB_W-1:0] UNDEF_CODE     = 32'h0000_0020;
endpackage

// File: rtl/fsb_slot.sv
module fsb_slot
   import fsb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SLOT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic              sw_clr,
   input  logic [DATA_W-1:0] sw_data,
   input  logic              hw_ld,
   input  logic [DATA_W-1:0] hw_data,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] shaped;

   // Per-slot software shaping rule
   generate
      if (SLOT == SLOT_CAUSE) begin : g_cause
         assign shaped = (sw_data & CAUSE_SW_KEEP) | CAUSE_SW_FORCE;
      end else if (SLOT == SLOT_VADDR) begin : g_vaddr
         assign shaped = sw_data;
      end else if (SLOT == SLOT_AUX) begin : g_aux
         assign shaped = sw_data & AUX_SW_KEEP;
      end else begin : g_ext
         assign shaped = {sw_data[EXT_SRC_BIT], sw_data[EXT_SRC_BIT],
                          sw_data[EXT_SRC_BIT:0]};
      end
   endgenerate

   // Priority: hardware load, software write, read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (hw_ld) begin
         q <= hw_data;
      end else if (sw_wr) begin
         q <= shaped;
      end else if (sw_clr) begin
         q <= '0;
      end
   end
endmodule

// File: rtl/fsb_fault_enc.sv
module fsb_fault_enc
   import fsb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              strobe,
   input  logic              is_write,
   input  logic              invalid,
   input  logic              undef,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [DATA_W-1:0] cause_q,
   output logic              cause_ld,
   output logic [DATA_W-1:0] cause_nx,
   output logic              vaddr_ld,
   output logic [DATA_W-1:0] vaddr_nx
);
   localparam logic [DATA_W-1:0] DIR_MASK = DATA_W'(1) << DIR_BIT;
   localparam logic [DATA_W-1:0] INV_MASK = DATA_W'(1) << INV_BIT;

   assign cause_ld = strobe && (invalid || undef);
   assign vaddr_ld = strobe;

   // Invalid entry merges into the held cause; undefined type replaces it
   always_comb begin
      if (invalid) begin
         if (is_write) cause_nx = cause_q | DIR_MASK | INV_MASK;
         else          cause_nx = (cause_q | INV_MASK) & ~DIR_MASK;
      end else begin
         cause_nx = is_write ? (UNDEF_CODE | DIR_MASK) : UNDEF_CODE;
      end
   end

   generate
      if (ADDR_W < DATA_W) begin : g_ext
         assign vaddr_nx = {{(DATA_W-ADDR_W){1'b0}}, vaddr};
      end else begin : g_full
         assign vaddr_nx = vaddr;
      end
   endgenerate
endmodule

// File: rtl/fsb_rd_mux.sv
module fsb_rd_mux #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned SLOTS  = 4
) (
   input  logic                         rd_en,
   input  logic [IDX_W-1:0]             idx,
   input  logic [SLOTS-1:0][DATA_W-1:0] slot_q,
   output logic [DATA_W-1:0]            rdata
);
   localparam int unsigned SEL_W = $clog2(SLOTS);

   always_comb begin
      rdata = '0;
      if (rd_en && (idx < IDX_W'(SLOTS))) begin
         rdata = slot_q[idx[SEL_W-1:0]];
      end
   end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
   import fsb_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_sel,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_idx,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic [DATA_W-1:0] sw_rdata,
   input  logic              flt_strobe,
   input  logic              flt_is_write,
   input  logic              flt_invalid,
   input  logic              flt_undef,
   input  logic [ADDR_W-1:0] flt_vaddr
);
   localparam int unsigned SLOTS = FSB_SLOTS;

   // Elaboration-time parameter checks
   generate
      if (DATA_W != FSB_W) begin : g_bad_w
         $error("fault_status_bank: DATA_W must be 32");
      end
      if (ADDR_W > DATA_W) begin : g_bad_a
         $error("fault_status_bank: ADDR_W exceeds DATA_W");
      end
      if ((1 << IDX_W) < SLOTS) begin : g_bad_i
         $error("fault_status_bank: IDX_W too narrow for slots");
      end
   endgenerate

   logic [SLOTS-1:0][DATA_W-1:0] slot_q;
   logic [SLOTS-1:0]             wr_vec;
   logic [SLOTS-1:0]             clr_vec;
   logic [SLOTS-1:0]             ld_vec;
   logic [SLOTS-1:0][DATA_W-1:0] ld_data;
   logic                         cause_ld;
   logic                         vaddr_ld;
   logic [DATA_W-1:0]            cause_nx;
   logic [DATA_W-1:0]            vaddr_nx;
   logic                         sw_rd;
   logic                         sw_go;

   assign sw_rd = sw_sel && !sw_we;
   assign sw_go = sw_sel && !flt_strobe;

   fsb_fault_enc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_enc (
      .strobe   (flt_strobe),
      .is_write (flt_is_write),
      .invalid  (flt_invalid),
      .undef    (flt_undef),
      .vaddr    (flt_vaddr),
      .cause_q  (slot_q[SLOT_CAUSE]),
      .cause_ld (cause_ld),
      .cause_nx (cause_nx),
      .vaddr_ld (vaddr_ld),
      .vaddr_nx (vaddr_nx)
   );

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         assign wr_vec[k]  = sw_go &&  sw_we && (sw_idx == IDX_W'(k));
         assign clr_vec[k] = sw_go && !sw_we && (sw_idx == IDX_W'(k));
         if (k == SLOT_CAUSE) begin : g_hw_c
            assign ld_vec[k]  = cause_ld;
            assign ld_data[k] = cause_nx;
         end else if (k == SLOT_VADDR) begin : g_hw_v
            assign ld_vec[k]  = vaddr_ld;
            assign ld_data[k] = vaddr_nx;
         end else begin : g_hw_n
            assign ld_vec[k]  = 1'b0;
            assign ld_data[k] = '0;
         end
         fsb_slot #(.DATA_W(DATA_W), .SLOT(k)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_wr   (wr_vec[k]),
            .sw_clr  (clr_vec[k]),
            .sw_data (sw_wdata),
            .hw_ld   (ld_vec[k]),
            .hw_data (ld_data[k]),
            .q       (slot_q[k])
         );
      end
   endgenerate

   fsb_rd_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) u_rd (
      .rd_en  (sw_rd),
      .idx    (sw_idx),
      .slot_q (slot_q),
      .rdata  (sw_rdata)
   );
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ADDR_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sw_sel,
   input logic                    sw_we,
   input logic [IDX_W-1:0]        sw_idx,
   input logic [DATA_W-1:0]       sw_wdata,
   input logic [DATA_W-1:0]       sw_rdata,
   input logic                    flt_strobe,
   input logic                    flt_is_write,
   input logic                    flt_invalid,
   input logic                    flt_undef,
   input logic [ADDR_W-1:0]       flt_vaddr,
   input logic [3:0][DATA_W-1:0]  slot_q
);
   localparam logic [IDX_W-1:0] N_IDX = IDX_W'(4);

   p_rdclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_sel && !sw_we && sw_idx < N_IDX && !flt_strobe)
      |=> slot_q[$past(sw_idx[1:0])] == '0);

   p_cause_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_sel && sw_we && sw_idx == IDX_W'(0) && !flt_strobe)
      |=> slot_q[0] == ({24'h0, $past(sw_wdata[7:0])} | 32'h8000));

   p_aux_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_sel && sw_we && sw_idx == IDX_W'(2) && !flt_strobe)
      |=> slot_q[2] == ($past(sw_wdata) & 32'hB0));

   p_ext_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q[3][31] == slot_q[3][29]) && (slot_q[3][30] == slot_q[3][29]));

   p_inv_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_strobe && flt_invalid && !flt_is_write)
      |=> slot_q[0][7] && !slot_q[0][15]);

   p_inv_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_strobe && flt_invalid && flt_is_write)
      |=> slot_q[0][7] && slot_q[0][15]);

   p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_strobe && flt_undef && !flt_invalid)
      |=> slot_q[0] == ($past(flt_is_write) ? 32'h8020 : 32'h20));

   p_fault_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flt_strobe |=> slot_q[1] == DATA_W'($past(flt_vaddr)));

   p_fault_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_strobe && sw_sel && sw_idx == IDX_W'(2)) |=> $stable(slot_q[2]));

   p_hi_idx_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_sel && !sw_we && sw_idx >= N_IDX) |-> sw_rdata == '0);
endmodule

bind fault_status_bank fsb_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sw_sel       (sw_sel),
   .sw_we        (sw_we),
   .sw_idx       (sw_idx),
   .sw_wdata     (sw_wdata),
   .sw_rdata     (sw_rdata),
   .flt_strobe   (flt_strobe),
   .flt_is_write (flt_is_write),
   .flt_invalid  (flt_invalid),
   .flt_undef    (flt_undef),
   .flt_vaddr    (flt_vaddr),
   .slot_q       (slot_q)
);

// File: tb/fault_status_bank_bench.sv
`timescale 1ns/1ps
module fault_status_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_sel = 1'b0, sw_we = 1'b0;
   logic [3:0]  sw_idx = '0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] sw_rdata;
   logic        flt_strobe = 1'b0, flt_is_write = 1'b0;
   logic        flt_invalid = 1'b0, flt_undef = 1'b0;
   logic [31:0] flt_vaddr = '0;

   int checks = 0;
   int failures = 0;
   logic [31:0] m [4];

   always #2.5 clk = ~clk;

   fault_status_bank u_fault_status_bank (
      .clk(clk), .rst_n(rst_n), .sw_sel(sw_sel), .sw_we(sw_we),
      .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
      .flt_strobe(flt_strobe), .flt_is_write(flt_is_write),
      .flt_invalid(flt_invalid), .flt_undef(flt_undef),
      .flt_vaddr(flt_vaddr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // One clock of stimulus; read data compared, then model advanced
   task automatic step(input logic sel, input logic we, input logic [3:0] idx,
                       input logic [31:0] wd, input logic fs, input logic fw,
                       input logic fi, input logic fu, input logic [31:0] va,
                       input string tag);
      logic [31:0] exp;
      @(negedge clk);
      sw_sel = sel; sw_we = we; sw_idx = idx; sw_wdata = wd;
      flt_strobe = fs; flt_is_write = fw; flt_invalid = fi; flt_undef = fu;
      flt_vaddr = va;
      #1;
      exp = (sel && !we && idx < 4) ? m[idx[1:0]] : 32'h0;
      check(tag, sw_rdata, exp);
      @(posedge clk);
      if (fs) begin
         if (fi) begin
            if (fw) m[0] = m[0] | 32'h8080;
            else    m[0] = (m[0] | 32'h80) & ~32'h8000;
         end else if (fu) begin
            m[0] = fw ? 32'h8020 : 32'h20;
         end
         m[1] = va;
      end else if (sel && idx < 4) begin
         if (we) begin
            case (idx[1:0])
               2'd0: m[0] = (wd & 32'hFF) | 32'h8000;
               2'd1: m[1] = wd;
               2'd2: m[2] = wd & 32'hB0;
               default: m[3] = {wd[29], wd[29], wd[29:0]};
            endcase
         end else begin
            m[idx[1:0]] = 32'h0;
         end
      end
   endtask

   task automatic rd(input logic [3:0] idx, input string tag);
      step(1, 0, idx, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic wr(input logic [3:0] idx, input logic [31:0] d, input string tag);
      step(1, 1, idx, d, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic flt(input logic fw, input logic fi, input logic fu,
                      input logic [31:0] va, input string tag);
      step(0, 0, 0, 0, 1, fw, fi, fu, va, tag);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) m[i] = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 4; i++) rd(4'(i), "R1");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
      // R3 slot 0 shaping, R2 destructive read
      wr(0, 32'hFFFF_FFFF, "R3"); rd(0, "R3"); rd(0, "R2");
      wr(0, 32'h0000_7F00, "R3"); rd(0, "R3");
      // R4
      wr(1, 32'hDEAD_BEEF, "R4"); rd(1, "R4"); rd(1, "R2");
      // R5
      wr(2, 32'hFFFF_FFFF, "R5"); rd(2, "R5");
      wr(2, 32'h0000_004F, "R5"); rd(2, "R5");
      // R6
      wr(3, 32'h2000_0001, "R6"); rd(3, "R6");
      wr(3, 32'hDFFF_FFFF, "R6"); rd(3, "R6");
      // R7 invalid read merges
      wr(0, 32'h12, "R7"); flt(0, 1, 0, 32'h1234_5678, "R7");
      rd(0, "R7"); rd(1, "R10");
      // R8 invalid write merges
      wr(0, 32'h01, "R8"); flt(1, 1, 0, 32'hFFFF_FFFC, "R8");
      rd(0, "R8"); rd(1, "R10");
      // R9 undefined type replaces; invalid wins when both
      wr(0, 32'hFF, "R9"); flt(0, 0, 1, 32'h4, "R9"); rd(0, "R9");
      wr(0, 32'hFF, "R9"); flt(1, 0, 1, 32'h8, "R9"); rd(0, "R9");
      flt(0, 1, 1, 32'hC, "R9"); rd(0, "R9");
      // R10 strobe without cause keeps slot 0
      wr(0, 32'h5A, "R10"); flt(1, 0, 0, 32'hA5A5_0000, "R10");
      rd(0, "R10"); rd(1, "R10");
      // R11 fault wins over software in the same cycle
      wr(2, 32'hB0, "R11");
      step(1, 1, 2, 32'h0, 1, 0, 0, 0, 32'h100, "R11"); rd(2, "R11");
      wr(1, 32'h0BAD_F00D, "R11");
      step(1, 0, 1, 32'h0, 1, 0, 1, 0, 32'h200, "R11"); rd(1, "R11");
      // R12 high indices
      wr(0, 32'h33, "R12"); wr(3, 32'h7, "R12");
      wr(5, 32'hFFFF_FFFF, "R12"); rd(9, "R12"); rd(15, "R12");
      rd(0, "R12"); rd(3, "R12");
      // Mixed random traffic against the model
      for (int n = 0; n < 400; n++) begin
         logic fs;
         fs = (($urandom % 8) == 0);
         step($urandom % 2, $urandom % 2, 4'($urandom % 6), $urandom, fs,
              $urandom % 2, $urandom % 2, $urandom % 2, $urandom, "R2 mix");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule